// File: doc/BRIEF.md
# Multiprocessor-Filtering Serial Receiver

This block is the receive side of a four-mode serial port of the kind found next to small microcontroller cores. A two-bit mode input picks one of four framings: a clocked shift register where the block drives the shift clock, an asynchronous 8-bit frame, or one of two asynchronous 9-bit frames. One 9-bit mode runs at a fixed rate derived from the core clock. The other asynchronous modes run from an external 16x sample tick. Received bytes land in a holding register, with a ninth-bit status and a sticky receive flag that only software clears.

The shift register and the holding register form a two-stage buffer, so a new frame can arrive while the previous byte is still unread. When the new frame finishes, it replaces the unread byte. With the multiprocessor enable set, a frame is dropped without touching the holding register if its last bit is 0. In the 9-bit modes that bit is the ninth data bit. In 8-bit mode it is the stop bit. Address bytes carry a 1 there, so a listening node can ignore data meant for other nodes.

Top module: `uart_mp_rx`

## Requirements
- R1: After reset, rx_flag_o, data_o and bit9_o are 0 and sclk_o is 1.
- R2: In mode 01 the line idles high, a frame is a low start bit, then 8 data bits LSB first, then a stop bit. The byte goes to data_o and the stop bit value goes to bit9_o.
- R3: In mode 01 with mp_en_i set, a frame whose stop bit is 0 leaves data_o, bit9_o and rx_flag_o unchanged. With mp_en_i clear, the same frame is accepted and bit9_o reads 0.
- R4: In modes 10 and 11, a ninth data bit follows the eighth data bit and is written to bit9_o.
- R5: In modes 10 and 11 with mp_en_i set, a frame whose ninth bit is 0 leaves the holding register and flag unchanged. A frame whose ninth bit is 1 is accepted.
- R6: Mode 10 ignores baud_tick_i and times its bits from the core clock: 64 clocks per bit with fix_fast_i low, and 32 with fix_fast_i high.
- R7: In modes 01 to 11, rx_flag_o rises during the second half of the stop bit, not before the stop bit's midpoint.
- R8: While a new frame is being received, data_o keeps the previous byte. On completion, the new byte replaces it even if rx_flag_o was still set.
- R9: rx_flag_o stays set until a one-cycle pulse on flag_clr_i.
- R10: While rx_en_i is low, no frame is received.
- R11: Each bit is taken as the majority of samples 7, 8 and 9 of 16. A low pulse that is high again at mid-bit is discarded as a false start.
- R12: In mode 00, while rx_en_i is high and rx_flag_o is clear, the block drives 8 low-high periods on sclk_o, each 2 core clocks long. It samples rxd_i at each rising edge, LSB first, and sets rx_flag_o after the eighth. bit9_o is not changed. No further shifting starts while rx_flag_o is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Serial receive line |
| baud_tick_i | input | 1 | 16x sample tick for modes 01 and 11 |
| mode_i | input | 2 | 00 shift, 01 8-bit, 10 fixed-rate 9-bit, 11 variable 9-bit |
| rx_en_i | input | 1 | Receive enable |
| mp_en_i | input | 1 | Multiprocessor address filter enable |
| fix_fast_i | input | 1 | Mode 10 rate select: 1 = 32 clocks per bit |
| flag_clr_i | input | 1 | Clear strobe for rx_flag_o |
| sclk_o | output | 1 | Shift clock in mode 00, idles high |
| data_o | output | DATA_W | Holding register |
| bit9_o | output | 1 | Ninth bit, or the stop bit in mode 01 |
| rx_flag_o | output | 1 | Receive-complete flag |

## Verification
The bench sends frames of different byte values in all four modes. Asymmetric values show LSB-first ordering and bit9 polarity. Each stop or ninth bit is tried as both 0 and 1, with the filter on and off, which separates filtering on the stop bit from filtering on the ninth bit. Mode 10 runs at two rates with the external tick stopped, which shows that its timing comes from the core clock alone. A frame that lands on an unread byte, a short low glitch, a disabled receiver and a flag probe on each side of the stop-bit midpoint cover overwrite, false-start rejection, enable gating and flag timing.

// File: rtl/uart_mp_rx_pkg.sv
package uart_mp_rx_pkg;
  typedef enum logic [1:0] {
    MD_SHIFT = 2'b00,
    MD_UART8 = 2'b01,
    MD_FIX9  = 2'b10,
    MD_VAR9  = 2'b11
  } rx_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick
  import uart_mp_rx_pkg::*;
#(
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  rx_mode_e mode_i,
  input  logic     fast_i,
  input  logic     ext_tick_i,
  output logic     tick_o
);
  localparam int MAXD = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int DW   = (MAXD > 2) ? $clog2(MAXD) : 1;

  logic [DW-1:0] div_cnt;
  logic [DW-1:0] lim;
  logic          int_tick;

  assign lim = fast_i ? DW'(FAST_DIV - 1) : DW'(SLOW_DIV - 1);

  always_ff @(posedge clk) begin
    if (rst || mode_i != MD_FIX9) begin
      div_cnt  <= '0;
      int_tick <= 1'b0;
    end else if (div_cnt >= lim) begin
      div_cnt  <= '0;
      int_tick <= 1'b1;
    end else begin
      div_cnt  <= div_cnt + 1'b1;
      int_tick <= 1'b0;
    end
  end

  assign tick_o = (mode_i == MD_FIX9) ? int_tick : ext_tick_i;

  a_r6_fixed_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MD_FIX9 && int_tick) |=> !int_tick);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_mp_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en_i,
  input  rx_mode_e          mode_i,
  input  logic              flag_i,
  input  logic              rxd_s_i,
  input  logic              rxd_raw_i,
  input  logic              tick_i,
  output logic              sclk_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              shift_o
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] V0   = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] V1   = CW'(OVS / 2);
  localparam logic [CW-1:0] V2   = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] BLST = BW'(DATA_W - 1);

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [1:0]        votes;
  logic [DATA_W-1:0] shreg;
  logic              ninth_q;
  logic              phase;
  logic              maj;
  logic              nine;

  assign maj  = (votes[0] & votes[1]) | (votes[0] & rxd_s_i) | (votes[1] & rxd_s_i);
  assign nine = mode_i[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      votes   <= '0;
      shreg   <= '0;
      ninth_q <= 1'b0;
      phase   <= 1'b0;
      sclk_o  <= 1'b1;
      done_o  <= 1'b0;
      data_o  <= '0;
      bit9_o  <= 1'b0;
      shift_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!rx_en_i) begin
        st     <= ST_IDLE;
        sclk_o <= 1'b1;
        phase  <= 1'b0;
      end else begin
        case (st)
          ST_IDLE: begin
            sclk_o <= 1'b1;
            phase  <= 1'b0;
            bidx   <= '0;
            if (mode_i == MD_SHIFT) begin
              if (!flag_i && !done_o) st <= ST_SHIFT;
            end else if (tick_i && !rxd_s_i) begin
              st  <= ST_START;
              cnt <= CW'(1);
            end
          end
          ST_SHIFT: begin
            if (!phase) begin
              sclk_o <= 1'b0;
              phase  <= 1'b1;
            end else begin
              sclk_o <= 1'b1;
              phase  <= 1'b0;
              shreg  <= {rxd_raw_i, shreg[DATA_W-1:1]};
              bidx   <= bidx + 1'b1;
              if (bidx == BLST) begin
                st      <= ST_IDLE;
                done_o  <= 1'b1;
                data_o  <= {rxd_raw_i, shreg[DATA_W-1:1]};
                shift_o <= 1'b1;
              end
            end
          end
          default: begin
            if (tick_i) begin
              cnt <= cnt + 1'b1;
              if (cnt == V0) votes[0] <= rxd_s_i;
              if (cnt == V1) votes[1] <= rxd_s_i;
              if (cnt == V2) begin
                case (st)
                  ST_START: if (maj) st <= ST_IDLE;
                  ST_DATA:  shreg <= {maj, shreg[DATA_W-1:1]};
                  ST_NINTH: ninth_q <= maj;
                  ST_STOP: begin
                    st      <= ST_IDLE;
                    done_o  <= 1'b1;
                    data_o  <= shreg;
                    bit9_o  <= nine ? ninth_q : maj;
                    shift_o <= 1'b0;
                  end
                  default: st <= ST_IDLE;
                endcase
              end
              if (cnt == LAST) begin
                case (st)
                  ST_START: begin
                    st   <= ST_DATA;
                    bidx <= '0;
                  end
                  ST_DATA: begin
                    if (bidx == BLST) st <= nine ? ST_NINTH : ST_STOP;
                    else              bidx <= bidx + 1'b1;
                  end
                  ST_NINTH: st <= ST_STOP;
                  default:  st <= st;
                endcase
              end
            end
          end
        endcase
      end
    end
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r10_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !rx_en_i |=> (st == ST_IDLE && !done_o));
  a_r12_hold_while_flag: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && mode_i == MD_SHIFT && flag_i) |=> st != ST_SHIFT);
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_mp_rx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int OVS          = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int FIX_SLOW_DIV = 4,
  parameter int FIX_FAST_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd_i,
  input  logic              baud_tick_i,
  input  logic [1:0]        mode_i,
  input  logic              rx_en_i,
  input  logic              mp_en_i,
  input  logic              fix_fast_i,
  input  logic              flag_clr_i,
  output logic              sclk_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              rx_flag_o
);
  rx_mode_e          mode;
  logic              rxd_s;
  logic              tick;
  logic              f_done;
  logic [DATA_W-1:0] f_data;
  logic              f_bit9;
  logic              f_shift;
  logic              accept;

  assign mode = rx_mode_e'(mode_i);

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(rxd_i), .q_o(rxd_s)
  );

  uart_rx_tick #(.SLOW_DIV(FIX_SLOW_DIV), .FAST_DIV(FIX_FAST_DIV)) u_tick (
    .clk(clk), .rst(rst), .mode_i(mode), .fast_i(fix_fast_i),
    .ext_tick_i(baud_tick_i), .tick_o(tick)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk(clk), .rst(rst), .rx_en_i(rx_en_i), .mode_i(mode),
    .flag_i(rx_flag_o), .rxd_s_i(rxd_s), .rxd_raw_i(rxd_i), .tick_i(tick),
    .sclk_o(sclk_o), .done_o(f_done), .data_o(f_data), .bit9_o(f_bit9),
    .shift_o(f_shift)
  );

  // Stop bit (8-bit mode) and ninth bit (9-bit modes) share the f_bit9 field.
  assign accept = f_done && (f_shift || !mp_en_i || f_bit9);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o    <= '0;
      bit9_o    <= 1'b0;
      rx_flag_o <= 1'b0;
    end else begin
      if (flag_clr_i) rx_flag_o <= 1'b0;
      if (accept) begin
        data_o    <= f_data;
        rx_flag_o <= 1'b1;
        if (!f_shift) bit9_o <= f_bit9;
      end
    end
  end

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_flag_o && !flag_clr_i) |=> rx_flag_o);
  // covers R3 and R5: filtered frames leave the holding register alone
  a_r5_mp_filter: assert property (@(posedge clk) disable iff (rst)
    (f_done && !f_shift && mp_en_i && !f_bit9) |=> ($stable(data_o) && $stable(bit9_o)));
  a_r8_load_on_frame: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_o) |-> $past(f_done));
endmodule

// File: tb/uart_mp_rx_tb.sv
module uart_mp_rx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       baud_tick = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       rx_en = 1'b1;
  logic       mp_en = 1'b0;
  logic       fast = 1'b0;
  logic       clr = 1'b0;
  logic       sclk;
  logic [7:0] data;
  logic       bit9;
  logic       flag;
  logic       tick_en = 1'b1;
  int         tcnt = 0;
  int         total = 0;
  int         bad = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt      <= (tcnt == 3) ? 0 : tcnt + 1;
    baud_tick <= tick_en && (tcnt == 3);
  end

  uart_mp_rx u_dut (
    .clk(clk), .rst(rst), .rxd_i(rxd), .baud_tick_i(baud_tick), .mode_i(mode),
    .rx_en_i(rx_en), .mp_en_i(mp_en), .fix_fast_i(fast), .flag_clr_i(clr),
    .sclk_o(sclk), .data_o(data), .bit9_o(bit9), .rx_flag_o(flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic has9, input logic b9,
                      input logic stopv, input int bc);
    drive_bit(1'b0, bc);
    for (int i = 0; i < 8; i++) drive_bit(d[i], bc);
    if (has9) drive_bit(b9, bc);
    drive_bit(stopv, bc);
    drive_bit(1'b1, 2 * bc);
  endtask

  task automatic clear_flag();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 flag", flag, 0);
    chk("R1 data", data, 0);
    chk("R1 bit9", bit9, 0);
    chk("R1 sclk", sclk, 1);
  endtask

  task automatic t_mode1_basic();
    mode = 2'b01; mp_en = 0;
    send(8'hA5, 0, 0, 1, 64);
    chk("R2 data", data, 8'hA5);
    chk("R2 stop->bit9", bit9, 1);
    chk("R2 flag", flag, 1);
    repeat (200) @(negedge clk);
    chk("R9 flag held", flag, 1);
    clear_flag();
    chk("R9 flag cleared", flag, 0);
  endtask

  task automatic t_mode1_mp();
    mp_en = 1;
    send(8'h3C, 0, 0, 0, 64);
    chk("R3 bad stop flag", flag, 0);
    chk("R3 bad stop data", data, 8'hA5);
    send(8'h3C, 0, 0, 1, 64);
    chk("R3 good stop data", data, 8'h3C);
    chk("R3 good stop flag", flag, 1);
    clear_flag();
    mp_en = 0;
    send(8'h5A, 0, 0, 0, 64);
    chk("R3 no filter flag", flag, 1);
    chk("R3 no filter data", data, 8'h5A);
    chk("R3 no filter bit9", bit9, 0);
    clear_flag();
  endtask

  task automatic t_mode3_ninth();
    mode = 2'b11; mp_en = 0;
    send(8'h81, 1, 0, 1, 64);
    chk("R4 data", data, 8'h81);
    chk("R4 ninth 0", bit9, 0);
    send(8'h7E, 1, 1, 1, 64);
    chk("R4 data2", data, 8'h7E);
    chk("R4 ninth 1", bit9, 1);
    clear_flag();
  endtask

  task automatic t_mode3_mp();
    mp_en = 1;
    send(8'h11, 1, 0, 1, 64);
    chk("R5 filtered flag", flag, 0);
    chk("R5 filtered data", data, 8'h7E);
    send(8'h22, 1, 1, 1, 64);
    chk("R5 address data", data, 8'h22);
    chk("R5 address flag", flag, 1);
    clear_flag();
    mp_en = 0;
  endtask

  task automatic t_mode2_rate();
    tick_en = 0; mode = 2'b10; fast = 0;
    send(8'h96, 1, 1, 1, 64);
    chk("R6 slow data", data, 8'h96);
    chk("R6 slow bit9", bit9, 1);
    clear_flag();
    fast = 1;
    send(8'h4B, 1, 0, 1, 32);
    chk("R6 fast data", data, 8'h4B);
    chk("R6 fast bit9", bit9, 0);
    chk("R6 fast flag", flag, 1);
    clear_flag();
    fast = 0; tick_en = 1; mode = 2'b01;
  endtask

  task automatic t_flag_timing();
    logic [7:0] d;
    d = 8'h55;
    drive_bit(1'b0, 64);
    for (int i = 0; i < 8; i++) drive_bit(d[i], 64);
    drive_bit(1'b1, 16);
    chk("R7 flag before mid-stop", flag, 0);
    drive_bit(1'b1, 40);
    chk("R7 flag after mid-stop", flag, 1);
    drive_bit(1'b1, 128);
    clear_flag();
  endtask

  task automatic t_overwrite();
    logic [7:0] d;
    send(8'h12, 0, 0, 1, 64);
    chk("R8 first", data, 8'h12);
    d = 8'h34;
    drive_bit(1'b0, 64);
    for (int i = 0; i < 4; i++) drive_bit(d[i], 64);
    chk("R8 held during rx", data, 8'h12);
    chk("R8 flag during rx", flag, 1);
    for (int i = 4; i < 8; i++) drive_bit(d[i], 64);
    drive_bit(1'b1, 64);
    drive_bit(1'b1, 128);
    chk("R8 overwritten", data, 8'h34);
    chk("R8 flag", flag, 1);
    clear_flag();
  endtask

  task automatic t_disable();
    rx_en = 0;
    send(8'hF0, 0, 0, 1, 64);
    chk("R10 no flag", flag, 0);
    chk("R10 data kept", data, 8'h34);
    rx_en = 1;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_false_start();
    drive_bit(1'b0, 16);
    drive_bit(1'b1, 400);
    chk("R11 glitch flag", flag, 0);
    chk("R11 glitch data", data, 8'h34);
    send(8'hC3, 0, 0, 1, 64);
    chk("R11 next frame", data, 8'hC3);
    clear_flag();
  endtask

  task automatic t_mode0();
    logic [7:0] d;
    logic       b9_before;
    int         rises;
    d = 8'hB2;
    b9_before = bit9;
    rises = 0;
    @(negedge clk) mode = 2'b00;
    for (int i = 0; i < 8; i++) begin
      while (sclk !== 1'b0) @(negedge clk);
      rxd = d[i];
      @(negedge clk);
      if (sclk === 1'b1) rises++;
    end
    rxd = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 rises", rises, 8);
    chk("R12 data", data, 8'hB2);
    chk("R12 flag", flag, 1);
    chk("R12 bit9 unchanged", bit9, b9_before);
    begin
      logic low_seen;
      low_seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (sclk !== 1'b1) low_seen = 1;
      end
      chk("R12 no shift while flag", low_seen, 0);
    end
    @(negedge clk) mode = 2'b01;
    clear_flag();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode1_basic();
    t_mode1_mp();
    t_mode3_ninth();
    t_mode3_mp();
    t_mode2_rate();
    t_flag_timing();
    t_overwrite();
    t_disable();
    t_false_start();
    t_mode0();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule